// File: doc/BRIEF.md
# Glitch-free one-hot line scan sequencer

This block drives sixteen mutually exclusive line-select outputs for a multiplexed display. A single advance strobe moves the scan to the next line. Between two lines, every select output is held low for a programmable number of clock cycles, so the old line and the new one are never on together and no other line flashes on while the position changes.

The position is kept in a four-bit state register. A build-time parameter chooses plain binary counting or reflected Gray counting, in which only one state bit toggles per step. In both variants the reported index is the binary line number. The select outputs and the index are both registered and change together on one clock edge.

The blanking length is read when an advance is accepted, and also while reset is held. A later change to it has no effect on a window that is already running. An advance strobe that arrives during a window is ignored. A strobe held high steps the scan once per window plus one cycle.

Top module: `scan_sel_top`

## Requirements
- R1: While reset is high, and for L+1 cycles after it falls (L = blank length sampled on the last reset edge), every select line is low and the index is 0; then line 0 (bit 0) goes high with no advance applied.
- R2: At most one select bit is ever high. When one is high, it is the bit whose position equals the index output.
- R3: With blank length L > 0, an advance sampled while a line is shown drives all select lines low on that edge. They stay low for exactly L cycles with the index unchanged. On the next edge the index becomes (index+1) mod 16 and its line goes high.
- R4: With blank length 0, an accepted advance moves the index and the selected line directly on the sampling edge, with no all-low cycle.
- R5: An advance sampled during a blanking window is ignored: it neither restarts nor shortens the window and adds no step.
- R6: From index 15 an accepted step goes to index 0 and select bit 0.
- R7: In Gray mode the internal state code changes in exactly one bit per step. The index and select outputs follow the same sequence and timing as binary mode.
- R8: The blank length is sampled on the edge that accepts the advance. Changes during the window do not alter its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_i | input | 1 | Advance strobe, sampled each rising edge |
| blank_len_i | input | 4 | Blanking window length in cycles (0 to 15) |
| sel_o | output | 16 | One-hot line selects, registered |
| idx_o | output | 4 | Binary index of the current line, registered |

## Verification
The end of a blanking window and a new advance request can meet in the same cycle. So can an advance and a change of blank length. The bench holds the strobe high for long stretches so that a request is present on the very edge where a window closes. It also changes the length during windows and at the accepting edge. A behavioural model counts remaining blank cycles on its own. Every clock, it predicts the select word and index for a binary and a Gray instance driven in parallel, so a swallowed, doubled or early step shows up as a miscompare on the first wrong cycle.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic {PH_SHOW = 1'b0, PH_BLANK = 1'b1} phase_t;
endpackage

// File: rtl/scan_timer.sv
module scan_timer
  import scan_pkg::*;
#(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_i,
  input  logic [LW-1:0] len_i,
  output logic          take_o,
  output logic          finish_o,
  output logic          blanking_o,
  output logic          step_o,
  output logic          show_o,
  output logic          clear_o
);
  phase_t        ph_q;
  logic [LW-1:0] cnt_q;
  logic          pend_q;   // window was opened by an advance, not by reset
  logic          direct;

  always_comb begin
    blanking_o = (ph_q == PH_BLANK);
    take_o     = !blanking_o && adv_i;
    finish_o   = blanking_o && (cnt_q == '0);
    direct     = take_o && (len_i == '0);
    step_o     = direct || (finish_o && pend_q);
    show_o     = direct || finish_o;
    clear_o    = take_o && (len_i != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_BLANK;
      cnt_q  <= len_i;
      pend_q <= 1'b0;
    end else if (clear_o) begin
      ph_q   <= PH_BLANK;
      cnt_q  <= len_i - 1'b1;
      pend_q <= 1'b1;
    end else if (finish_o) begin
      ph_q   <= PH_SHOW;
      pend_q <= 1'b0;
    end else if (blanking_o) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/scan_state.sv
module scan_state #(
  parameter int IW   = 4,
  parameter bit GRAY = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  output logic [IW-1:0] cur_o,
  output logic [IW-1:0] nxt_o,
  output logic [IW-1:0] code_o
);
  function automatic logic [IW-1:0] to_gray(input logic [IW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [IW-1:0] from_gray(input logic [IW-1:0] g);
    logic [IW-1:0] b;
    b[IW-1] = g[IW-1];
    for (int i = IW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [IW-1:0] code_q;

  assign nxt_o  = cur_o + 1'b1;
  assign code_o = code_q;

  generate
    if (GRAY) begin : g_gray
      assign cur_o = from_gray(code_q);
      always_ff @(posedge clk) begin
        if (rst)         code_q <= '0;
        else if (step_i) code_q <= to_gray(nxt_o);
      end
    end else begin : g_bin
      assign cur_o = code_q;
      always_ff @(posedge clk) begin
        if (rst)         code_q <= '0;
        else if (step_i) code_q <= nxt_o;
      end
    end
  endgenerate
endmodule

// File: rtl/scan_out_reg.sv
module scan_out_reg #(
  parameter int IW = 4,
  parameter int N  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          clear_i,
  input  logic [IW-1:0] idx_i,
  output logic [N-1:0]  sel_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] hit;

  generate
    for (genvar i = 0; i < N; i++) begin : g_dec
      assign hit[i] = (idx_i == IW'(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o <= '0;
      idx_o <= '0;
    end else if (load_i) begin
      sel_o <= hit;
      idx_o <= idx_i;
    end else if (clear_i) begin
      sel_o <= '0;
    end
  end
endmodule

// File: rtl/scan_sel_top.sv
module scan_sel_top #(
  parameter int IW       = 4,
  parameter int LW       = 4,
  parameter bit USE_GRAY = 1'b0,
  localparam int N       = 1 << IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_i,
  input  logic [LW-1:0] blank_len_i,
  output logic [N-1:0]  sel_o,
  output logic [IW-1:0] idx_o
);
  logic          take_w, finish_w, blanking_w, step_w, show_w, clear_w;
  logic [IW-1:0] cur_w, nxt_w, code_w, tgt_w;

  scan_timer #(.LW(LW)) u_timer (
    .clk(clk), .rst(rst), .adv_i(adv_i), .len_i(blank_len_i),
    .take_o(take_w), .finish_o(finish_w), .blanking_o(blanking_w),
    .step_o(step_w), .show_o(show_w), .clear_o(clear_w)
  );

  scan_state #(.IW(IW), .GRAY(USE_GRAY)) u_state (
    .clk(clk), .rst(rst), .step_i(step_w),
    .cur_o(cur_w), .nxt_o(nxt_w), .code_o(code_w)
  );

  assign tgt_w = step_w ? nxt_w : cur_w;

  scan_out_reg #(.IW(IW), .N(N)) u_out (
    .clk(clk), .rst(rst), .load_i(show_w), .clear_i(clear_w),
    .idx_i(tgt_w), .sel_o(sel_o), .idx_o(idx_o)
  );
endmodule

// File: rtl/scan_sel_chk.sv
module scan_sel_chk #(
  parameter int IW   = 4,
  parameter int LW   = 4,
  parameter bit GRAY = 1'b0,
  localparam int N   = 1 << IW
) (
  input logic          clk,
  input logic          rst,
  input logic          adv_i,
  input logic [LW-1:0] len_i,
  input logic [N-1:0]  sel_o,
  input logic [IW-1:0] idx_o,
  input logic          take,
  input logic          finish,
  input logic          blanking,
  input logic          step,
  input logic [IW-1:0] code
);
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (sel_o == '0) && (idx_o == '0));

  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_o));

  a_r2_match: assert property (@(posedge clk) disable iff (rst)
    (sel_o != '0) |-> (sel_o == (N'(1) << idx_o)));

  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    (take && (len_i != '0)) |=> (sel_o == '0) && $stable(idx_o));

  a_r4_direct: assert property (@(posedge clk) disable iff (rst)
    (take && (len_i == '0)) |=> (sel_o != '0));

  a_r5_ignore: assert property (@(posedge clk) disable iff (rst)
    (blanking && adv_i && !finish) |=> (sel_o == '0) && $stable(idx_o));

  a_r6_step: assert property (@(posedge clk) disable iff (rst)
    step |=> (idx_o == IW'($past(idx_o) + 1'b1)));

  generate
    if (GRAY) begin : g_gray_chk
      a_r7_one_bit: assert property (@(posedge clk) disable iff (rst)
        step |=> ($countones(code ^ $past(code)) == 1));
    end
  endgenerate
endmodule

bind scan_sel_top scan_sel_chk #(.IW(IW), .LW(LW), .GRAY(USE_GRAY)) u_chk (
  .clk(clk), .rst(rst), .adv_i(adv_i), .len_i(blank_len_i),
  .sel_o(sel_o), .idx_o(idx_o), .take(take_w), .finish(finish_w),
  .blanking(blanking_w), .step(step_w), .code(code_w)
);

// File: tb/scan_sel_top_tb.sv
module scan_sel_top_tb;
  localparam int IW = 4;
  localparam int LW = 4;
  localparam int N  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          adv = 1'b0;
  logic [LW-1:0] blen = 4'd3;
  logic [N-1:0]  sel_b, sel_g;
  logic [IW-1:0] idx_b, idx_g;

  int    vecs = 0, bad = 0, cyc = 0;
  string tag = "R1";
  bit    live = 1'b0, done = 1'b0;

  // reference model state
  int m_idx = 0, m_rem = 0;
  bit m_busy = 1'b0, m_on = 1'b0, m_adv = 1'b0;

  always #4 clk = ~clk;

  scan_sel_top #(.IW(IW), .LW(LW), .USE_GRAY(1'b0)) u_dut (
    .clk(clk), .rst(rst), .adv_i(adv), .blank_len_i(blen),
    .sel_o(sel_b), .idx_o(idx_b)
  );

  scan_sel_top #(.IW(IW), .LW(LW), .USE_GRAY(1'b1)) u_dut_g (
    .clk(clk), .rst(rst), .adv_i(adv), .blank_len_i(blen),
    .sel_o(sel_g), .idx_o(idx_g)
  );

  always @(posedge clk) begin
    live = 1'b1;
    if (rst) begin
      m_idx = 0; m_on = 1'b0; m_busy = 1'b1; m_adv = 1'b0;
      m_rem = int'(blen) + 1;
    end else if (m_busy) begin
      m_rem = m_rem - 1;
      if (m_rem == 0) begin
        m_busy = 1'b0;
        m_on   = 1'b1;
        if (m_adv) m_idx = (m_idx + 1) % N;
      end
    end else if (adv) begin
      if (blen == 0) begin
        m_idx = (m_idx + 1) % N;
      end else begin
        m_busy = 1'b1; m_on = 1'b0; m_adv = 1'b1;
        m_rem  = int'(blen);
      end
    end
  end

  task automatic compare(input string who, input logic [N-1:0] s,
                         input logic [IW-1:0] i, input string t);
    logic [N-1:0] es;
    es = m_on ? (N'(1) << m_idx) : '0;
    vecs++;
    if (s !== es || i !== IW'(m_idx)) begin
      bad++;
      $display("FAIL %s [%s] cycle %0d: sel=%h idx=%0d expected sel=%h idx=%0d",
               t, who, cyc, s, i, es, m_idx);
    end
    vecs++;
    if ($countones(s) > 1) begin  // R2 mutual exclusion
      bad++;
      $display("FAIL R2 [%s] cycle %0d: sel=%h expected at most one bit", who, cyc, s);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      compare("bin", sel_b, idx_b, tag);
      compare("gray", sel_g, idx_g, {tag, "/R7"});
      cyc++;
      if (cyc > 150000) begin
        bad++;
        $display("FAIL watchdog: run did not finish, cycle %0d expected below 150000", cyc);
        summary();
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk) adv = 1'b1;
    @(negedge clk) adv = 1'b0;
  endtask

  initial begin
    // R1: reset window then line 0 without advance
    tag = "R1"; rst = 1'b1; blen = 4'd3;
    tick(3); rst = 1'b0; tick(8);

    // R3: single advances with different window lengths
    tag = "R3";
    blen = 4'd3;  pulse(); tick(6);
    blen = 4'd1;  pulse(); tick(3);
    blen = 4'd15; pulse(); tick(18);

    // R8: length altered at and after the accepting edge
    tag = "R8"; blen = 4'd5;
    @(negedge clk) adv = 1'b1;
    @(negedge clk) begin adv = 1'b0; blen = 4'd1; end
    tick(2); blen = 4'd9; tick(8);

    // R5: strobe held through windows, request present on closing edges
    tag = "R5"; blen = 4'd4; adv = 1'b1; tick(40); adv = 1'b0; tick(6);

    // R4: zero-length window, strobe held, wraps several times
    tag = "R4"; blen = 4'd0; adv = 1'b1; tick(40); adv = 1'b0; tick(3);

    // R6: wrap with short windows
    tag = "R6"; blen = 4'd2;
    for (int k = 0; k < 20; k++) begin pulse(); tick(3); end

    // R3: sweep every window length
    tag = "R3";
    for (int k = 0; k < 16; k++) begin blen = LW'(k); pulse(); tick(k + 2); end

    // R1: reset in mid run with zero length
    tag = "R1"; blen = 4'd0; rst = 1'b1; tick(2); rst = 1'b0; tick(4);
    tag = "R4"; pulse(); tick(3);

    summary();
  end
endmodule